// File: doc/BRIEF.md
# Snoop Retry Bus-Request Gate

This block sits between each bus master on a shared, snooped address bus and the central arbiter. It watches the bus address-retry line and each master's own snoop state. From these it decides, cycle by cycle, whether the master's bus request reaches the arbiter and whether a grant from the arbiter is honoured.

When a retry is qualified, the following clock becomes a one-cycle window reserved for the snooper that caused the retry and still owes a copyback. In that window every other master withholds its request, and all masters disregard grant. This lets the arbiter take back a grant it has already issued, and it lets the copyback win the bus before the retried transfer restarts. A master whose own address tenure was retried receives an abort pulse in the same window.

If a snooper already holds an earlier copyback when a new snoop hits, it uses the window for that older copyback. A select output flags this case.

Top module: `srg_bus_gate`

## Requirements
- R1: After synchronous active-low reset, abort and old-copyback select are 0 for every master, no window is open, and each bus request equals the internal request.
- R2: A retry is qualified only when `retry_i` and `sample_i` are both 1 at the same rising edge. A retry with `sample_i` at 0 opens no window and raises no abort.
- R3: The window lasts exactly the one clock following a qualified retry. Qualified retries on consecutive edges give consecutive window cycles.
- R4: In the window, master i drives bus request 1 only if, at the qualifying edge, it had `own_retry_i[i]`=1 and either `hit_dirty_i[i]` or `cb_pending_i[i]` was 1. Every other master drives 0, whatever its internal request.
- R5: In the window, effective grant is 0 for every master, whatever `gnt_i` is.
- R6: Outside the window, bus request equals internal request, and effective grant equals `gnt_i` AND bus request.
- R7: `abort_o[i]` is 1 exactly in the window cycle, and only if `xfer_active_i[i]` was 1 at the qualifying edge.
- R8: `cb_old_sel_o[i]` is 1 exactly in the window cycle, and only if master i was the window owner (R4) with `cb_pending_i[i]`=1 at the qualifying edge. This means the older copyback is serviced before the new hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retry_i | input | 1 | Bus address-retry line |
| sample_i | input | 1 | Marks the retry-sampling cycle of an active address tenure |
| req_int_i | input | NUM_MASTERS | Internal bus request per master |
| own_retry_i | input | NUM_MASTERS | Master itself drives retry this cycle |
| hit_dirty_i | input | NUM_MASTERS | Current snoop hit needs a copyback |
| cb_pending_i | input | NUM_MASTERS | An earlier copyback is still owed |
| xfer_active_i | input | NUM_MASTERS | Master's own address tenure is in progress |
| gnt_i | input | NUM_MASTERS | Grant from arbiter |
| bus_req_o | output | NUM_MASTERS | Request presented to the arbiter |
| gnt_eff_o | output | NUM_MASTERS | Grant the master may act on |
| abort_o | output | NUM_MASTERS | Abort pulse for a retried transfer |
| cb_old_sel_o | output | NUM_MASTERS | Window copyback must use the older pending entry |

## Verification
The bench builds the block with NUM_MASTERS=4. With four masters, one cycle can hold a window owner, a retried master, and bystanders with their internal request and grant high. This shows that R4 and R5 suppress each master independently.

Random stimulus gives retries often enough that back-to-back qualified retries and unqualified retries (sample low) both occur. Directed cases cover an owner with an older pending copyback and a retry whose sample strobe is low.

// File: rtl/srg_pkg.sv
// Package: per-master state captured at a qualified retry edge.
package srg_pkg;

    typedef struct packed {
        logic snoop_win;  // master owns the reserved window
        logic old_cb;     // window serves the older pending copyback
        logic abort;      // master's own tenure was retried
    } srg_hold_t;

endpackage

// File: rtl/srg_window_track.sv
// Module: srg_window_track
// Tracks the shared reserved window. A retry is qualified when the retry
// line is high in the sampling cycle of an active tenure. The window is
// the single clock after each qualified retry.
// Assumes: retry_i and sample_i are synchronous to clk.
module srg_window_track (
    input  logic clk,
    input  logic rst_n,
    input  logic retry_i,
    input  logic sample_i,
    output logic qual_o,
    output logic win_o
);

    logic win_q;

    // Qualification of the current retry.
    assign qual_o = retry_i && sample_i;

    // Open the window for one clock after a qualified retry.
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= 1'b0;
        else        win_q <= qual_o;
    end

    assign win_o = win_q;

endmodule

// File: rtl/srg_master_gate.sv
// Module: srg_master_gate
// Per-master gating of request and grant around the reserved window.
// The decision is taken at the qualifying edge and held for the window.
// Assumes: win_i is high exactly one clock after qual_i.
module srg_master_gate
    import srg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic qual_i,
    input  logic win_i,
    input  logic req_int_i,
    input  logic own_retry_i,
    input  logic hit_dirty_i,
    input  logic cb_pending_i,
    input  logic xfer_active_i,
    input  logic gnt_i,
    output logic bus_req_o,
    output logic gnt_eff_o,
    output logic abort_o,
    output logic cb_old_sel_o
);

    srg_hold_t hold_d;
    srg_hold_t hold_q;

    // Decide window ownership, copyback choice and abort at the retry edge.
    always_comb begin
        hold_d.snoop_win = qual_i && own_retry_i && (hit_dirty_i || cb_pending_i);
        hold_d.old_cb    = qual_i && own_retry_i && cb_pending_i;
        hold_d.abort     = qual_i && xfer_active_i;
    end

    // Hold the decision for the window cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    // Request: owner only in the window, otherwise the internal request.
    always_comb begin
        if (win_i) bus_req_o = hold_q.snoop_win;
        else       bus_req_o = req_int_i;
    end

    // Grant: blocked in the window, else honoured while requesting.
    assign gnt_eff_o    = !win_i && gnt_i && bus_req_o;
    assign abort_o      = hold_q.abort;
    assign cb_old_sel_o = hold_q.old_cb;

endmodule

// File: rtl/srg_bus_gate.sv
// Module: srg_bus_gate (top)
// Request/grant gate for NUM_MASTERS masters sharing one snooped address
// bus. One shared window tracker and one gate per master.
// Assumes: all signals active-high, one clock, synchronous reset.
module srg_bus_gate #(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   retry_i,
    input  logic                   sample_i,
    input  logic [NUM_MASTERS-1:0] req_int_i,
    input  logic [NUM_MASTERS-1:0] own_retry_i,
    input  logic [NUM_MASTERS-1:0] hit_dirty_i,
    input  logic [NUM_MASTERS-1:0] cb_pending_i,
    input  logic [NUM_MASTERS-1:0] xfer_active_i,
    input  logic [NUM_MASTERS-1:0] gnt_i,
    output logic [NUM_MASTERS-1:0] bus_req_o,
    output logic [NUM_MASTERS-1:0] gnt_eff_o,
    output logic [NUM_MASTERS-1:0] abort_o,
    output logic [NUM_MASTERS-1:0] cb_old_sel_o
);

    localparam int LAST = NUM_MASTERS - 1;

    logic qual;
    logic win;

    srg_window_track u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .retry_i  (retry_i),
        .sample_i (sample_i),
        .qual_o   (qual),
        .win_o    (win)
    );

    // One gate per master.
    for (genvar m = 0; m <= LAST; m++) begin : g_master
        srg_master_gate u_gate (
            .clk           (clk),
            .rst_n         (rst_n),
            .qual_i        (qual),
            .win_i         (win),
            .req_int_i     (req_int_i[m]),
            .own_retry_i   (own_retry_i[m]),
            .hit_dirty_i   (hit_dirty_i[m]),
            .cb_pending_i  (cb_pending_i[m]),
            .xfer_active_i (xfer_active_i[m]),
            .gnt_i         (gnt_i[m]),
            .bus_req_o     (bus_req_o[m]),
            .gnt_eff_o     (gnt_eff_o[m]),
            .abort_o       (abort_o[m]),
            .cb_old_sel_o  (cb_old_sel_o[m])
        );
    end

endmodule

// File: rtl/srg_bus_gate_chk.sv
// Module: srg_bus_gate_chk
// Port-level temporal checks for srg_bus_gate, attached by bind.
module srg_bus_gate_chk #(
    parameter int NUM_MASTERS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   retry_i,
    input logic                   sample_i,
    input logic [NUM_MASTERS-1:0] req_int_i,
    input logic [NUM_MASTERS-1:0] own_retry_i,
    input logic [NUM_MASTERS-1:0] hit_dirty_i,
    input logic [NUM_MASTERS-1:0] cb_pending_i,
    input logic [NUM_MASTERS-1:0] xfer_active_i,
    input logic [NUM_MASTERS-1:0] gnt_i,
    input logic [NUM_MASTERS-1:0] bus_req_o,
    input logic [NUM_MASTERS-1:0] gnt_eff_o,
    input logic [NUM_MASTERS-1:0] abort_o,
    input logic [NUM_MASTERS-1:0] cb_old_sel_o
);

    a_r5_grant_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_i && sample_i) |=> (gnt_eff_o == '0));

    a_r4_owner_only_req: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_i && sample_i) |=>
        (bus_req_o == $past(own_retry_i & (hit_dirty_i | cb_pending_i))));

    a_r7_abort_retried: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_i && sample_i) |=> (abort_o == $past(xfer_active_i)));

    a_r8_old_copyback: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_i && sample_i) |=> (cb_old_sel_o == $past(own_retry_i & cb_pending_i)));

    a_r2_no_window: assert property (@(posedge clk) disable iff (!rst_n)
        !(retry_i && sample_i) |=> (abort_o == '0 && cb_old_sel_o == '0));

    a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !(retry_i && sample_i) |=>
        (bus_req_o == req_int_i && gnt_eff_o == (gnt_i & req_int_i)));

endmodule

bind srg_bus_gate srg_bus_gate_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .retry_i       (retry_i),
    .sample_i      (sample_i),
    .req_int_i     (req_int_i),
    .own_retry_i   (own_retry_i),
    .hit_dirty_i   (hit_dirty_i),
    .cb_pending_i  (cb_pending_i),
    .xfer_active_i (xfer_active_i),
    .gnt_i         (gnt_i),
    .bus_req_o     (bus_req_o),
    .gnt_eff_o     (gnt_eff_o),
    .abort_o       (abort_o),
    .cb_old_sel_o  (cb_old_sel_o)
);

// File: tb/tb_srg_bus_gate.sv
module tb_srg_bus_gate;

    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic retry_i = 1'b0;
    logic sample_i = 1'b0;
    logic [N-1:0] req_int_i = '0, own_retry_i = '0, hit_dirty_i = '0;
    logic [N-1:0] cb_pending_i = '0, xfer_active_i = '0, gnt_i = '0;
    logic [N-1:0] bus_req_o, gnt_eff_o, abort_o, cb_old_sel_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference state, updated at each rising edge.
    bit         m_win = 1'b0;
    bit [N-1:0] m_own = '0, m_old = '0, m_abt = '0;

    always #5 clk = ~clk;

    srg_bus_gate #(.NUM_MASTERS(N)) dut (
        .clk(clk), .rst_n(rst_n), .retry_i(retry_i), .sample_i(sample_i),
        .req_int_i(req_int_i), .own_retry_i(own_retry_i), .hit_dirty_i(hit_dirty_i),
        .cb_pending_i(cb_pending_i), .xfer_active_i(xfer_active_i), .gnt_i(gnt_i),
        .bus_req_o(bus_req_o), .gnt_eff_o(gnt_eff_o), .abort_o(abort_o),
        .cb_old_sel_o(cb_old_sel_o)
    );

    function automatic bit [N-1:0] exp_req();
        return m_win ? m_own : req_int_i;
    endfunction

    function automatic bit [N-1:0] exp_gnt();
        return m_win ? '0 : (gnt_i & exp_req());
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the reference, mid-cycle.
    task automatic check_all(input string tag);
        check({tag, " R4/R6 bus_req"}, bus_req_o, exp_req());
        check({tag, " R5/R6 gnt_eff"}, gnt_eff_o, exp_gnt());
        check({tag, " R7 abort"}, abort_o, m_abt);
        check({tag, " R8 cb_old_sel"}, cb_old_sel_o, m_old);
    endtask

    // Advance the reference model one edge using the applied inputs.
    always @(posedge clk) begin
        bit q;
        q = retry_i && sample_i;
        if (!rst_n) begin
            m_win <= 1'b0; m_own <= '0; m_old <= '0; m_abt <= '0;
        end else begin
            m_win <= q;
            m_own <= q ? (own_retry_i & (hit_dirty_i | cb_pending_i)) : '0;
            m_old <= q ? (own_retry_i & cb_pending_i) : '0;
            m_abt <= q ? xfer_active_i : '0;
        end
    end

    // Drive inputs after the falling edge, then check before the rising edge.
    task automatic cycle(input bit rt, input bit sp, input logic [N-1:0] rq,
                         input logic [N-1:0] ow, input logic [N-1:0] hd,
                         input logic [N-1:0] cp, input logic [N-1:0] xa,
                         input logic [N-1:0] gn, input string tag);
        @(negedge clk);
        retry_i = rt; sample_i = sp; req_int_i = rq; own_retry_i = ow;
        hit_dirty_i = hd; cb_pending_i = cp; xfer_active_i = xa; gnt_i = gn;
        #2;
        check_all(tag);
    endtask

    initial begin : watchdog
        #2000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, requests pass through
        req_int_i = 4'b1010; gnt_i = 4'b1111; #2;
        check("R1 abort reset", abort_o, '0);
        check("R1 cb_old reset", cb_old_sel_o, '0);
        check("R1 bus_req reset", bus_req_o, 4'b1010);
        @(negedge clk); rst_n = 1'b1;

        // R6: plain pass-through
        cycle(0, 0, 4'b1111, 0, 0, 0, 0, 4'b0110, "R6 idle");
        // R2: unqualified retry opens no window
        cycle(1, 0, 4'b1111, 4'b0001, 4'b0001, 0, 4'b0010, 4'b1111, "R2 unq");
        cycle(0, 0, 4'b1111, 0, 0, 0, 0, 4'b1111, "R2 after unq");
        check("R2 no abort", abort_o, '0);
        // R3/R4/R7/R8: qualified retry; master1 owner with older pending, master2 retried
        cycle(1, 1, 4'b1111, 4'b0011, 4'b0001, 4'b0010, 4'b0100, 4'b1111, "R3 qual");
        cycle(0, 0, 4'b1111, 0, 0, 0, 0, 4'b1111, "R3 window");
        check("R4 owner req", bus_req_o, 4'b0011);
        check("R5 no grant", gnt_eff_o, 4'b0000);
        check("R7 abort m2", abort_o, 4'b0100);
        check("R8 old cb m1", cb_old_sel_o, 4'b0010);
        cycle(0, 0, 4'b1111, 0, 0, 0, 0, 4'b1111, "R3 closed");
        check("R3 window one cycle", gnt_eff_o, 4'b1111);
        // R3: back-to-back qualified retries
        cycle(1, 1, 4'b0101, 4'b1000, 4'b1000, 0, 4'b0001, 4'b1111, "R3 b2b a");
        cycle(1, 1, 4'b0101, 4'b0100, 0, 4'b0100, 4'b0010, 4'b1111, "R3 b2b b");
        check("R3 second window abort", abort_o, 4'b0001);
        cycle(0, 0, 4'b0101, 0, 0, 0, 0, 4'b1111, "R3 b2b c");
        check("R3 second window req", bus_req_o, 4'b0100);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            bit rt;
            rt = ($urandom % 3) == 0;
            cycle(rt, ($urandom % 4) != 0, N'($urandom), N'($urandom), N'($urandom),
                  N'($urandom), N'($urandom), N'($urandom), "rand");
            if (($urandom % 500) == 0) begin
                @(negedge clk); rst_n = 1'b0;
                @(negedge clk); #2;
                check("R1 mid reset abort", abort_o, '0);
                rst_n = 1'b1;
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule